// File: doc/BRIEF.md
# Duty-Programmable Clock Divider

This block divides an input clock by a ratio built from two separately set counts. One count gives the number of input cycles the output stays high and the other gives the number it stays low, so one setting fixes both the period and the duty cycle. A divide-by-10 clock can be 50/50 (5 and 5) or 40/60 (4 and 6). Each count is 8 bits wide, and a count of zero stands for 256 cycles.

A bypass input sends the input clock straight to the output, which gives divide-by-1. An odd-divide input moves the falling edge of the output from a rising edge of the input clock to the falling edge half a cycle earlier. The high phase then loses half a cycle and the low phase gains it, so an odd ratio such as 2+1 gives an even 1.5/1.5 split. Rising output edges always stay on rising input edges.

The counts and the odd-divide setting are taken only at the rising edge that starts a high phase, so a period already under way always runs to its end. Inside the block, a two-state machine clocked on the rising edge (states LOW and HIGH) does the counting. A register on the falling edge trims the last half cycle in odd mode, and an output selector merges the two and applies the bypass. Reset holds the machine in LOW with one cycle left, so the first rising edge after reset is released takes the transition LOW→HIGH. The other transitions are HIGH→LOW, when the high count expires, and LOW→HIGH, when the low count expires.

Top module: `duty_clk_div`

## Requirements
- R1: While `rst_n` is low and `bypass` is 0, `clk_out` is 0. The first rising edge of `clk_in` after `rst_n` goes high starts a high phase.
- R2: With `bypass` 0 and `odd_sel` 0, `clk_out` is high for `hi_cnt` input cycles and then low for `lo_cnt` input cycles, so the period is `hi_cnt + lo_cnt` cycles.
- R3: With `bypass` 1, `clk_out` equals `clk_in` at once, whatever the other inputs are. The counting goes on in the background, so clearing `bypass` resumes the sequence at the point the counting has reached.
- R4: With `odd_sel` 0, every edge of `clk_out` follows a rising edge of `clk_in`. With either setting of `odd_sel`, the rising edge of `clk_out` follows a rising edge of `clk_in`.
- R5: With `odd_sel` 1, `clk_out` falls on the falling edge of `clk_in` in the last high cycle, so the high time is `hi_cnt` − 0.5 cycles and the low time is `lo_cnt` + 0.5 cycles. For example, `hi_cnt`=2 and `lo_cnt`=1 give a divide-by-3 clock with 1.5 cycles high and 1.5 cycles low, and `hi_cnt`=1 gives a half-cycle pulse.
- R6: A value of 0 on `hi_cnt` or `lo_cnt` means 256 cycles.
- R7: `hi_cnt`, `lo_cnt` and `odd_sel` are sampled only at the rising edge that starts a high phase. A change at any other time does not affect the period in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cnt | input | 8 | High time in input cycles (0 means 256) |
| lo_cnt | input | 8 | Low time in input cycles (0 means 256) |
| bypass | input | 1 | 1: output is the input clock |
| odd_sel | input | 1 | 1: falling output edge moved to the falling input edge |
| clk_out | output | 1 | Divided clock |

## Verification
A wrong state or count in the machine shows up within one output period as a high or low phase of the wrong length. The bench samples `clk_out` in both halves of every input cycle, so a phase that is one cycle too long or too short shows up within that period. A stuck or mistimed falling-edge trim register changes only the second half of the last high cycle, and is therefore seen only in that half-cycle sample. A count that is latched at the wrong time shows up in the first period that follows a mid-period change of the inputs, as a phase length that matches the new value too early.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } dcd_state_e;
endpackage

// File: rtl/dcd_phase_fsm.sv
`timescale 1ns/1ps
module dcd_phase_fsm
    import dcd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             odd_sel,
    output logic             phase_hi,
    output logic             last_hi,
    output logic             odd_mode
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    dcd_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lo_len_q, lo_len_d;
    logic          odd_q, odd_d;

    // a zero count stands for the full 2**CNT_W cycles
    function automatic logic [CW-1:0] widen(input logic [CNT_W-1:0] v);
        return (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_LOW;
            cnt_q    <= ONE;
            lo_len_q <= ONE;
            odd_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            lo_len_q <= lo_len_d;
            odd_q    <= odd_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q - ONE;
        lo_len_d = lo_len_q;
        odd_d    = odd_q;
        unique case (state_q)
            ST_LOW: begin
                if (cnt_q == ONE) begin
                    state_d  = ST_HIGH;
                    cnt_d    = widen(hi_cnt);
                    lo_len_d = widen(lo_cnt);
                    odd_d    = odd_sel;
                end
            end
            ST_HIGH: begin
                if (cnt_q == ONE) begin
                    state_d = ST_LOW;
                    cnt_d   = lo_len_q;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        phase_hi = (state_q == ST_HIGH);
        last_hi  = (state_q == ST_HIGH) && (cnt_q == ONE);
        odd_mode = odd_q;
    end
endmodule

// File: rtl/dcd_half_trim.sv
`timescale 1ns/1ps
module dcd_half_trim (
    input  logic clk,
    input  logic rst_n,
    input  logic last_hi,
    input  logic odd_mode,
    output logic cut
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cut <= 1'b0;
        else        cut <= last_hi & odd_mode;
    end
endmodule

// File: rtl/dcd_out_sel.sv
`timescale 1ns/1ps
module dcd_out_sel (
    input  logic clk,
    input  logic bypass,
    input  logic phase_hi,
    input  logic cut,
    output logic clk_out
);
    always_comb begin
        if (bypass) clk_out = clk;
        else        clk_out = phase_hi & ~cut;
    end
endmodule

// File: rtl/duty_clk_div.sv
`timescale 1ns/1ps
module duty_clk_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             bypass,
    input  logic             odd_sel,
    output logic             clk_out
);
    logic phase_hi;
    logic last_hi;
    logic odd_mode;
    logic cut;

    dcd_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .odd_sel  (odd_sel),
        .phase_hi (phase_hi),
        .last_hi  (last_hi),
        .odd_mode (odd_mode)
    );

    dcd_half_trim u_trim (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .last_hi  (last_hi),
        .odd_mode (odd_mode),
        .cut      (cut)
    );

    dcd_out_sel u_sel (
        .clk      (clk_in),
        .bypass   (bypass),
        .phase_hi (phase_hi),
        .cut      (cut),
        .clk_out  (clk_out)
    );
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker (
    input logic clk_in,
    input logic rst_n,
    input logic bypass,
    input logic clk_out,
    input logic phase_hi,
    input logic last_hi,
    input logic odd_mode
);
    // R3: bypass passes the input clock (low before a rising edge)
    assert_bypass_low_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        bypass |-> !clk_out);

    // R3: bypass passes the input clock (high before a falling edge)
    assert_bypass_high_R3: assert property (@(negedge clk_in) disable iff (!rst_n)
        bypass |-> clk_out);

    // R2: output low for the whole of a low phase
    assert_low_phase_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!bypass && !phase_hi) |-> !clk_out);

    // R4: output still high at the end of every high cycle but the last
    assert_high_body_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!bypass && phase_hi && !last_hi) |-> clk_out);

    // R5: last high cycle ends low in odd mode, high in normal mode
    assert_last_half_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!bypass && phase_hi && last_hi) |-> (clk_out == !odd_mode));

    // R7: odd setting held for the whole high phase
    assert_odd_held_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase_hi && $past(phase_hi)) |-> $stable(odd_mode));
endmodule

bind duty_clk_div dcd_checker u_chk (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .bypass   (bypass),
    .clk_out  (clk_out),
    .phase_hi (phase_hi),
    .last_hi  (last_hi),
    .odd_mode (odd_mode)
);

// File: tb/duty_clk_div_test.sv
`timescale 1ns/1ps
module duty_clk_div_test;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [7:0] hi_cnt = 8'd1;
    logic [7:0] lo_cnt = 8'd1;
    logic       bypass = 1'b0;
    logic       odd_sel = 1'b0;
    logic       clk_out;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit first_period = 1'b0;
    int k = 0;
    int cur_h = 1, cur_l = 1;
    bit cur_odd = 1'b0;
    bit done = 1'b0;

    duty_clk_div uut (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .hi_cnt  (hi_cnt),
        .lo_cnt  (lo_cnt),
        .bypass  (bypass),
        .odd_sel (odd_sel),
        .clk_out (clk_out)
    );

    always #2 clk_in = ~clk_in;

    function automatic int len_of(input logic [7:0] v);
        return (v == 8'd0) ? 256 : int'(v);
    endfunction

    // expected output in half h (0: after rising edge, 1: after falling edge) of cycle idx
    function automatic bit exp_level(input int idx, input int h_len, input bit odd, input int half);
        if (half == 0) return (idx < h_len);
        return (idx < h_len - 1) || ((idx == h_len - 1) && !odd);
    endfunction

    task automatic check(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: clk_out got %0b expected %0b", req, $time, got, exp);
        end
    endtask

    function automatic string tag_now();
        if (bypass) return "R3";
        if (first_period) return "R1";
        if (len_of(hi_cnt) != cur_h || len_of(lo_cnt) != cur_l || odd_sel != cur_odd) return "R7";
        if (cur_h == 256 || cur_l == 256) return "R6";
        if (cur_odd) return "R5";
        return "R2";
    endfunction

    // reference monitor: samples both halves of every input cycle
    always @(posedge clk_in) begin
        if (running) begin
            #1;
            if (k == 0) begin
                cur_h   = len_of(hi_cnt);
                cur_l   = len_of(lo_cnt);
                cur_odd = odd_sel;
            end
            check(clk_out, bypass ? 1'b1 : exp_level(k, cur_h, cur_odd, 0), tag_now());
            #2;
            check(clk_out, bypass ? 1'b0 : exp_level(k, cur_h, cur_odd, 1),
                  (!bypass && k == cur_h - 1) ? (cur_odd ? "R5" : "R4") : tag_now());
            k++;
            if (k == cur_h + cur_l) begin
                k = 0;
                first_period = 1'b0;
            end
        end
    end

    task automatic set_cfg(input int h, input int l, input bit o, input bit b);
        @(posedge clk_in);
        #2.5;
        hi_cnt  = 8'(h);
        lo_cnt  = 8'(l);
        odd_sel = o;
        bypass  = b;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk_in);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        // R1: reset state
        hi_cnt = 8'd3; lo_cnt = 8'd2;
        repeat (4) begin
            @(posedge clk_in); #1;
            check(clk_out, 1'b0, "R1");
            #2;
            check(clk_out, 1'b0, "R1");
        end
        @(posedge clk_in); #2.5;
        rst_n = 1'b1;
        running = 1'b1;
        first_period = 1'b1;
        k = 0;
        wait_cycles(12);
        // R2: 50/50 and 40/60 divide-by-10
        set_cfg(5, 5, 0, 0); wait_cycles(30);
        set_cfg(4, 6, 0, 0); wait_cycles(30);
        // R5: odd divide-by-3 and half-cycle pulse
        set_cfg(2, 1, 1, 0); wait_cycles(15);
        set_cfg(1, 3, 1, 0); wait_cycles(12);
        set_cfg(3, 4, 1, 0); wait_cycles(21);
        // R4: single-cycle phases in normal mode
        set_cfg(1, 1, 0, 0); wait_cycles(10);
        // R3: bypass, then resume
        set_cfg(3, 2, 0, 1); wait_cycles(9);
        set_cfg(3, 2, 0, 0); wait_cycles(15);
        // R6: zero counts mean 256
        set_cfg(0, 1, 0, 0); wait_cycles(520);
        set_cfg(1, 0, 1, 0); wait_cycles(520);
        // R7 and mixed: random settings changed at arbitrary cycles
        for (int i = 0; i < 60; i++) begin
            int h, l;
            bit o, b;
            h = $urandom_range(1, 12);
            l = $urandom_range(1, 12);
            o = 1'($urandom_range(0, 1));
            b = ($urandom_range(0, 7) == 0);
            set_cfg(h, l, o, b);
            wait_cycles($urandom_range(1, 40));
        end
        wait_cycles(4);
        running = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule